// File: doc/BRIEF.md
# Procedure Launch Control and Status Capability

This block is a small register file that lives in a vendor-specific capability of a configuration space. It lets software start numbered hardware procedures, such as PHY reset, calibration and training steps, by writing a procedure number to a control word. It then reports progress through a status word that software polls. The real procedure engines sit behind a simple back-end handshake. The block raises a one-cycle start strobe with the procedure number. The back end answers with a done strobe and a result code.

Some numbers complete at once and never reach the back end: abort, no-op, unsupported numbers, and a repeat of the one-shot transmit impedance calibration. A write that arrives while a procedure is running aborts that procedure. The abort is signalled to the back end with a one-cycle abort strobe. The capability header and a fixed link-number word are also readable. Reads are combinational on a two-bit word index.

Top module: `proc_launch_ctrl`

## Requirements
- R1: Word index 0 reads the header: bits 7:0 = 0x09, bits 15:8 = parameter NEXT_PTR, bits 23:16 = parameter CAP_LEN, bits 31:24 = 0.
- R2: Word index 1 is status: bit 31 = running, bit 30 = complete, bits 3:0 = completion code, all other bits zero. Word index 2 is control: bits 7:0 = procedure number, other bits zero. Running and complete are never both set.
- R3: After a synchronous active-low reset, status and control read 0 and neither strobe is raised.
- R4: When idle, a control write of a number from 4 to 12 launches it, unless it is a suppressed repeat under R8. In the next cycle, running = 1, complete = 0 and code = 0. The control word reads the number, and be_start is high for exactly that cycle with be_proc equal to the number.
- R5: While running, be_done with no control write clears running, sets complete and latches be_code as the completion code. The control word keeps the number. be_done while idle has no effect.
- R6: A control write while running aborts the procedure. The result is running = 0, complete = 1 and code 3, with a one-cycle be_abort pulse. The written value is discarded, so control still reads the aborted number. This takes priority over a be_done in the same cycle.
- R7: When idle, these control writes complete in the next cycle without be_start: number 0 gives code 3, number 1 gives code 0, and numbers 2, 3 and 13 to 255 give code 4. In each case complete = 1 and control reads the written number.
- R8: Procedure 5 (ZCAL_PROC) runs at most once. After a run of it completes with code 0, a later write of 5 completes immediately with code 0 and raises no be_start. A run that ends with another code, or is aborted, does not count.
- R9: Word index 3 reads parameter LINK_NUM in bits 7:0 with the other bits zero. LINK_NUM must be 0, 1, 4 or 5.
- R10: Writes to word indices 0, 1 and 3 change nothing. In a control write only bits 7:0 of the write data are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_idx | input | 2 | Word index for reads and writes |
| reg_wr | input | 1 | Write strobe for the indexed word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the indexed word (combinational) |
| be_start | output | 1 | One-cycle launch strobe to the back end |
| be_abort | output | 1 | One-cycle abort strobe to the back end |
| be_proc | output | 8 | Current procedure number |
| be_done | input | 1 | Back-end completion strobe |
| be_code | input | 4 | Back-end completion code, valid with be_done |

## Verification
The launch path is tried with numbers from each class: abort, no-op, unsupported low numbers, a number above 12 written with stray upper bits, and in-range hardware numbers. Each class is separated by its completion code and by whether be_start fires. Back-end runs end in transient failure, permanent failure and success. The one-shot calibration is requested before and after a failed run and after a successful one, which shows that only a successful completion suppresses later runs. Writes while running, including one that lands in the same cycle as be_done, separate abort priority from normal completion. Writes to the other words and a stray be_done while idle show that they change nothing.

// File: rtl/proc_launch_pkg.sv
package proc_launch_pkg;

    localparam int DATA_W = 32;
    localparam int IDX_W  = 2;
    localparam int PNUM_W = 8;
    localparam int CODE_W = 4;

    localparam logic [IDX_W-1:0] IDX_HDR  = 2'd0;
    localparam logic [IDX_W-1:0] IDX_STAT = 2'd1;
    localparam logic [IDX_W-1:0] IDX_CTL  = 2'd2;
    localparam logic [IDX_W-1:0] IDX_LINK = 2'd3;

    localparam logic [7:0]        CAP_ID     = 8'h09;
    localparam logic [CODE_W-1:0] CODE_OK    = 4'd0;
    localparam logic [CODE_W-1:0] CODE_ABORT = 4'd3;
    localparam logic [CODE_W-1:0] CODE_UNSUP = 4'd4;

    typedef enum logic [1:0] {
        K_LAUNCH    = 2'd0,
        K_IMM_OK    = 2'd1,
        K_IMM_ABORT = 2'd2,
        K_IMM_UNSUP = 2'd3
    } kind_e;

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [CODE_W-1:0] code;
        logic [PNUM_W-1:0] num;
        logic              zcal;
        logic              start;
        logic              abort;
    } ctl_state_t;

endpackage

// File: rtl/proc_classify.sv
module proc_classify
    import proc_launch_pkg::*;
#(
    parameter int ABORT_PROC = 0,
    parameter int NOP_PROC   = 1,
    parameter int FIRST_HW   = 4,
    parameter int LAST_PROC  = 12,
    parameter int ZCAL_PROC  = 5
) (
    input  logic [PNUM_W-1:0] pnum,
    input  logic              zcal_seen,
    output kind_e             kind
);
    localparam logic [PNUM_W-1:0] P_ABORT = PNUM_W'(ABORT_PROC);
    localparam logic [PNUM_W-1:0] P_NOP   = PNUM_W'(NOP_PROC);
    localparam logic [PNUM_W-1:0] P_LO    = PNUM_W'(FIRST_HW);
    localparam logic [PNUM_W-1:0] P_HI    = PNUM_W'(LAST_PROC);
    localparam logic [PNUM_W-1:0] P_ZCAL  = PNUM_W'(ZCAL_PROC);

    logic in_hw_range;

    always_comb begin
        in_hw_range = (pnum >= P_LO) && (pnum <= P_HI);
        if (pnum == P_ABORT) begin
            kind = K_IMM_ABORT;
        end else if (pnum == P_NOP) begin
            kind = K_IMM_OK;
        end else if (pnum == P_ZCAL && zcal_seen) begin
            kind = K_IMM_OK;
        end else if (in_hw_range) begin
            kind = K_LAUNCH;
        end else begin
            kind = K_IMM_UNSUP;
        end
    end
endmodule

// File: rtl/proc_word_mux.sv
module proc_word_mux
    import proc_launch_pkg::*;
#(
    parameter logic [7:0] NEXT_PTR = 8'h00,
    parameter logic [7:0] CAP_LEN  = 8'h10,
    parameter int         LINK_NUM = 4
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic              busy,
    input  logic              done,
    input  logic [CODE_W-1:0] code,
    input  logic [PNUM_W-1:0] num,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [DATA_W-1:0] HDR_WORD  = {8'h00, CAP_LEN, NEXT_PTR, CAP_ID};
    localparam logic [DATA_W-1:0] LINK_WORD = {{(DATA_W-8){1'b0}}, 8'(LINK_NUM)};

    always_comb begin
        unique case (idx)
            IDX_HDR:  rdata = HDR_WORD;
            IDX_STAT: rdata = {busy, done, {(DATA_W-2-CODE_W){1'b0}}, code};
            IDX_CTL:  rdata = {{(DATA_W-PNUM_W){1'b0}}, num};
            default:  rdata = LINK_WORD;
        endcase
    end
endmodule

// File: rtl/proc_launch_ctrl.sv
module proc_launch_ctrl
    import proc_launch_pkg::*;
#(
    parameter logic [7:0] NEXT_PTR  = 8'h00,
    parameter logic [7:0] CAP_LEN   = 8'h10,
    parameter int         LINK_NUM  = 4,
    parameter int         FIRST_HW  = 4,
    parameter int         LAST_PROC = 12,
    parameter int         ZCAL_PROC = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_idx,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              be_start,
    output logic              be_abort,
    output logic [7:0]        be_proc,
    input  logic              be_done,
    input  logic [3:0]        be_code
);
    localparam logic [PNUM_W-1:0] P_ZCAL = PNUM_W'(ZCAL_PROC);

    ctl_state_t        st_d, st_q;
    kind_e             wr_kind;
    logic              ctl_wr;
    logic [PNUM_W-1:0] wr_num;
    logic              unused_wbits;

    assign ctl_wr       = reg_wr && (reg_idx == IDX_CTL);
    assign wr_num       = reg_wdata[PNUM_W-1:0];
    assign unused_wbits = ^reg_wdata[DATA_W-1:PNUM_W];

    proc_classify #(
        .FIRST_HW  (FIRST_HW),
        .LAST_PROC (LAST_PROC),
        .ZCAL_PROC (ZCAL_PROC)
    ) u_classify (
        .pnum      (wr_num),
        .zcal_seen (st_q.zcal),
        .kind      (wr_kind)
    );

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        st_d.abort = 1'b0;
        if (ctl_wr) begin
            if (st_q.busy) begin
                st_d.busy  = 1'b0;
                st_d.done  = 1'b1;
                st_d.code  = CODE_ABORT;
                st_d.abort = 1'b1;
            end else begin
                st_d.num = wr_num;
                unique case (wr_kind)
                    K_LAUNCH: begin
                        st_d.busy  = 1'b1;
                        st_d.done  = 1'b0;
                        st_d.code  = CODE_OK;
                        st_d.start = 1'b1;
                    end
                    K_IMM_OK: begin
                        st_d.done = 1'b1;
                        st_d.code = CODE_OK;
                    end
                    K_IMM_ABORT: begin
                        st_d.done = 1'b1;
                        st_d.code = CODE_ABORT;
                    end
                    default: begin
                        st_d.done = 1'b1;
                        st_d.code = CODE_UNSUP;
                    end
                endcase
            end
        end else if (st_q.busy && be_done) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
            st_d.code = be_code;
            if (st_q.num == P_ZCAL && be_code == CODE_OK) begin
                st_d.zcal = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    proc_word_mux #(
        .NEXT_PTR (NEXT_PTR),
        .CAP_LEN  (CAP_LEN),
        .LINK_NUM (LINK_NUM)
    ) u_mux (
        .idx   (reg_idx),
        .busy  (st_q.busy),
        .done  (st_q.done),
        .code  (st_q.code),
        .num   (st_q.num),
        .rdata (reg_rdata)
    );

    assign be_start = st_q.start;
    assign be_abort = st_q.abort;
    assign be_proc  = st_q.num;

    logic              mon_busy;
    logic              mon_done;
    logic              mon_zcal;
    logic [CODE_W-1:0] mon_code;
    logic [PNUM_W-1:0] mon_num;
    assign mon_busy = st_q.busy;
    assign mon_done = st_q.done;
    assign mon_zcal = st_q.zcal;
    assign mon_code = st_q.code;
    assign mon_num  = st_q.num;
endmodule

// File: rtl/proc_launch_ctrl_chk.sv
module proc_launch_ctrl_chk #(
    parameter int LINK_NUM  = 4,
    parameter int ZCAL_PROC = 5
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] reg_idx,
    input logic       reg_wr,
    input logic       be_start,
    input logic       be_abort,
    input logic [7:0] be_proc,
    input logic       be_done,
    input logic [3:0] be_code,
    input logic       mon_busy,
    input logic       mon_done,
    input logic       mon_zcal,
    input logic [3:0] mon_code,
    input logic [7:0] mon_num
);
    logic ctl_wr;
    assign ctl_wr = reg_wr && (reg_idx == 2'd2);

    initial begin
        a_r9_link_legal: assert (LINK_NUM == 0 || LINK_NUM == 1 || LINK_NUM == 4 || LINK_NUM == 5);
    end

    a_r4_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        be_start |-> (mon_busy && !mon_done));

    a_r2_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mon_busy && mon_done));

    a_r5_done_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_busy && be_done && !ctl_wr) |=>
            (!mon_busy && mon_done && mon_code == $past(be_code)));

    a_r6_write_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_busy && ctl_wr) |=> (be_abort && !mon_busy && mon_done && mon_code == 4'd3));

    a_r6_abort_keeps_num: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_busy && ctl_wr) |=> $stable(mon_num));

    a_r8_zcal_once: assert property (@(posedge clk) disable iff (!rst_n)
        (be_start && be_proc == 8'(ZCAL_PROC)) |-> !mon_zcal);

    a_r10_other_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !ctl_wr && !(mon_busy && be_done)) |=>
            ($stable(mon_num) && $stable(mon_code) && $stable(mon_busy) && $stable(mon_done)));
endmodule

bind proc_launch_ctrl proc_launch_ctrl_chk #(
    .LINK_NUM  (LINK_NUM),
    .ZCAL_PROC (ZCAL_PROC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_idx  (reg_idx),
    .reg_wr   (reg_wr),
    .be_start (be_start),
    .be_abort (be_abort),
    .be_proc  (be_proc),
    .be_done  (be_done),
    .be_code  (be_code),
    .mon_busy (mon_busy),
    .mon_done (mon_done),
    .mon_zcal (mon_zcal),
    .mon_code (mon_code),
    .mon_num  (mon_num)
);

// File: tb/proc_launch_ctrl_bench.sv
`timescale 1ns/1ps
module proc_launch_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_idx = 2'd1;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        be_start, be_abort;
    logic [7:0]  be_proc;
    logic        be_done = 1'b0;
    logic [3:0]  be_code = '0;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit live = 0;

    always #2.5 clk = ~clk;

    proc_launch_ctrl u_proc_launch_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .be_start(be_start),
        .be_abort(be_abort), .be_proc(be_proc), .be_done(be_done), .be_code(be_code)
    );

    // behavioural reference
    int m_busy, m_done, m_code, m_num, m_zcal, m_start, m_abort;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_code = 0; m_num = 0; m_zcal = 0;
            m_start = 0; m_abort = 0; live = 1;
        end else begin
            m_start = 0; m_abort = 0;
            if (reg_wr && reg_idx == 2) begin
                if (m_busy != 0) begin
                    m_busy = 0; m_done = 1; m_code = 3; m_abort = 1;
                end else begin
                    int n;
                    n = int'(reg_wdata[7:0]);
                    m_num = n;
                    m_done = 1;
                    if (n == 0) m_code = 3;
                    else if (n == 1) m_code = 0;
                    else if (n == 5 && m_zcal != 0) m_code = 0;
                    else if (n >= 4 && n <= 12) begin
                        m_busy = 1; m_done = 0; m_code = 0; m_start = 1;
                    end else m_code = 4;
                end
            end else if (m_busy != 0 && be_done) begin
                m_busy = 0; m_done = 1; m_code = int'(be_code);
                if (m_num == 5 && be_code == 0) m_zcal = 1;
            end
        end
    end

    function automatic logic [31:0] model_word(input logic [1:0] idx);
        case (idx)
            2'd0: return 32'h0010_0009;
            2'd1: return {m_busy[0], m_done[0], 26'b0, m_code[3:0]};
            2'd2: return {24'b0, m_num[7:0]};
            default: return 32'h0000_0004;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (live && rst_n) begin
            check("R2 per-cycle readback", reg_rdata, model_word(reg_idx));
            check("R4 per-cycle be_start", {31'b0, be_start}, m_start);
            check("R6 per-cycle be_abort", {31'b0, be_abort}, m_abort);
            check("R4 per-cycle be_proc", {24'b0, be_proc}, {24'b0, m_num[7:0]});
        end
        if (cycles > 20000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic idle_to();
        @(posedge clk); #1;
        reg_wr = 1'b0; be_done = 1'b0;
    endtask

    task automatic rd(input logic [1:0] idx, input logic [31:0] exp, input string tag);
        idle_to();
        reg_idx = idx;
        @(negedge clk);
        check(tag, reg_rdata, exp);
    endtask

    task automatic wr(input logic [1:0] idx, input logic [31:0] data);
        idle_to();
        reg_idx = idx; reg_wr = 1'b1; reg_wdata = data;
    endtask

    task automatic ctl(input logic [31:0] data, input bit exp_start, input bit exp_abort, input string tag);
        wr(2'd2, data);
        idle_to();
        reg_idx = 2'd1;
        @(negedge clk);
        check({tag, " start"}, {31'b0, be_start}, {31'b0, exp_start});
        check({tag, " abort"}, {31'b0, be_abort}, {31'b0, exp_abort});
    endtask

    task automatic finish_be(input logic [3:0] code);
        idle_to();
        be_done = 1'b1; be_code = code;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        rd(2'd0, 32'h0010_0009, "R1 header");
        rd(2'd3, 32'h0000_0004, "R9 link word");
        rd(2'd1, 32'h0, "R3 status after reset");
        rd(2'd2, 32'h0, "R3 control after reset");

        ctl(32'd1, 0, 0, "R7 nop");
        rd(2'd1, 32'h4000_0000, "R7 nop code 0");
        rd(2'd2, 32'd1, "R7 nop control");
        ctl(32'd2, 0, 0, "R7 proc2");
        rd(2'd1, 32'h4000_0004, "R7 proc2 unsupported");
        ctl(32'd3, 0, 0, "R7 proc3");
        rd(2'd1, 32'h4000_0004, "R7 proc3 unsupported");
        ctl(32'hABCD_0120, 0, 0, "R10 upper bits");
        rd(2'd2, 32'h20, "R10 only low byte used");
        rd(2'd1, 32'h4000_0004, "R7 above 12 unsupported");
        ctl(32'd0, 0, 0, "R7 abort idle");
        rd(2'd1, 32'h4000_0003, "R7 abort idle code 3");

        ctl(32'd4, 1, 0, "R4 launch 4");
        rd(2'd1, 32'h8000_0000, "R4 running");
        rd(2'd2, 32'd4, "R4 control shows running");
        finish_be(4'd1);
        rd(2'd1, 32'h4000_0001, "R5 transient code");
        rd(2'd2, 32'd4, "R5 control keeps last");
        finish_be(4'd2);
        rd(2'd1, 32'h4000_0001, "R5 done while idle ignored");

        ctl(32'd9, 1, 0, "R4 launch 9");
        ctl(32'd6, 0, 1, "R6 write while running");
        rd(2'd1, 32'h4000_0003, "R6 aborted code");
        rd(2'd2, 32'd9, "R6 written value discarded");

        ctl(32'd7, 1, 0, "R4 launch 7");
        wr(2'd2, 32'd8);
        be_done = 1'b1; be_code = 4'd0;
        rd(2'd1, 32'h4000_0003, "R6 abort beats done");

        ctl(32'd5, 1, 0, "R8 first zcal");
        finish_be(4'd2);
        rd(2'd1, 32'h4000_0002, "R8 zcal permanent fail");
        ctl(32'd5, 1, 0, "R8 rerun after failure");
        finish_be(4'd0);
        rd(2'd1, 32'h4000_0000, "R8 zcal success");
        ctl(32'd5, 0, 0, "R8 zcal suppressed");
        rd(2'd1, 32'h4000_0000, "R8 suppressed code 0");

        ctl(32'd12, 1, 0, "R4 launch 12");
        wr(2'd0, 32'hFFFF_FFFF);
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd1, 32'h8000_0000, "R10 status unchanged");
        rd(2'd0, 32'h0010_0009, "R10 header unchanged");
        rd(2'd3, 32'h0000_0004, "R10 link unchanged");
        rd(2'd2, 32'd12, "R10 control unchanged");

        repeat (3) idle_to();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule